// File: doc/BRIEF.md
# Double-Cycle-Deselect Output Enable Pipeline

This block decides, cycle by cycle, whether a pipelined synchronous burst memory may drive its shared bidirectional data bus. An access decoder ahead of it has already registered the kind of each bus cycle: deselect, read start, read burst continue, or write. From that code, the active-low output enable pin and the sleep request, the block produces two outputs. One is the bus drive enable. The other is a strobe that tells the output data register to capture array data.

Read data reaches the bus one cycle after its cycle code, because it passes through the output register. When the device is deselected, bus drive is held for a parameterised number of extra cycles (one by default). A bus shared by several devices can therefore switch between them without an idle cycle. The bus stays released in four cases: the first cycle of a read that follows a deselect, any write cycle, after a write until a fresh read start, and during and after sleep. Outside those cases the output enable pin gates the drive combinationally.

Top module: `dcd_oe_pipe`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), drive_en is 0 and stays 0 until a read has been accepted, even with oe_n low.
- R2: Cycle code 2'b01 (read start) raises oreg_load in that same cycle. In the next cycle drive_en is 1 if oe_n is low and nothing else blocks it. Back-to-back read starts keep the bus driven.
- R3: Cycle code 2'b10 (burst continue) counts as a read, raising oreg_load and driving in the following cycle, only while a read burst is open. A read start opens a burst; a write, a deselect or sleep closes it.
- R4: When code 2'b00 (deselect) follows a read, the bus stays driven in the read-data cycle and then for DESEL_HOLD further consecutive deselect cycles, after which drive_en is 0. oreg_load is 0 in deselect cycles, so the held data does not change.
- R5: A read start in the cycle right after a deselect (or after reset or sleep) keeps drive_en at 0 in that cycle whatever oe_n is. This also cuts short any deselect hold still running.
- R6: oe_n high forces drive_en to 0, and oe_n low re-enables it, within the same cycle with no clock edge in between.
- R7: During a write cycle (code 2'b11) drive_en is 0 whatever oe_n is, and oreg_load is 0.
- R8: After a write, neither a burst continue nor a deselect drives the bus or loads the output register. Only a new read start does.
- R9: sleep_req high forces drive_en to 0 at once. Once it has been seen high at a clock edge, it clears all read and hold state for SLEEP_STAGES edges after the last edge at which it was high. After sleep the bus stays released until a new read start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_kind | input | 2 | Registered cycle code: 00 deselect, 01 read start, 10 burst continue, 11 write |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| drive_en | output | 1 | Data bus drive enable, active high |
| oreg_load | output | 1 | Output data register capture strobe |

## Verification
The bench builds two copies side by side. One uses the defaults (one hold cycle, two sleep synchroniser stages). The other uses DESEL_HOLD=2 and SLEEP_STAGES=3, which exercises the second stage of the hold chain and a longer sleep exit. Both copies get the same stimulus, so one sequence shows how the hold length and the sleep-exit timing shift with the parameters. Directed sequences cover a read start that cuts off a hold, a burst continue left orphaned by a write or by sleep, and oe_n toggled between clock edges. A pseudo-random stretch then mixes all four cycle codes with oe_n and sleep_req.

// File: rtl/dcd_oe_pipe_pkg.sv
// Package: shared cycle code type for the output enable pipeline.
// Assumes the decoder presents one of the four codes each cycle.
package dcd_oe_pipe_pkg;

    typedef enum logic [1:0] {
        CYC_DESEL    = 2'b00,
        CYC_RD_START = 2'b01,
        CYC_RD_CONT  = 2'b10,
        CYC_WRITE    = 2'b11
    } cyc_kind_t;

endpackage

// File: rtl/dcd_oe_sleep_sync.sv
// Sleep synchroniser: brings the asynchronous sleep request into the clock
// domain and keeps the internal sleep state active until STAGES edges have
// seen the request low. Assumes STAGES >= 1.
module dcd_oe_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic sleep_active
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single capture stage for the sleep request.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sleep_req;
            end
        end else begin : g_many
            // Purpose: shift the sleep request through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], sleep_req};
            end
        end
    endgenerate

    // Sleep state holds while any stage still carries the request.
    assign sleep_active = |sync_q;

endmodule

// File: rtl/dcd_oe_read_track.sv
// Read tracker: classifies the current cycle as a read that loads the
// output register, keeps the open-burst flag and the "was deselected"
// flag, and registers the read-valid stage that aligns drive with data.
// Assumes cyc_kind is already registered by the access decoder.
module dcd_oe_read_track
    import dcd_oe_pipe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_t kind,
    input  logic      sleep_active,
    output logic      rd_now,
    output logic      rd_valid,
    output logic      first_mask
);

    logic burst_open_q;
    logic was_desel_q;
    logic rd_valid_q;

    // Purpose: decide whether this cycle is an accepted read.
    always_comb begin
        rd_now = 1'b0;
        if (!sleep_active) begin
            if (kind == CYC_RD_START)                     rd_now = 1'b1;
            else if (kind == CYC_RD_CONT && burst_open_q) rd_now = 1'b1;
        end
    end

    // Purpose: track whether a read burst is open for burst continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_open_q <= 1'b0;
        end else if (sleep_active) begin
            burst_open_q <= 1'b0;
        end else begin
            case (kind)
                CYC_RD_START: burst_open_q <= 1'b1;
                CYC_WRITE:    burst_open_q <= 1'b0;
                CYC_DESEL:    burst_open_q <= 1'b0;
                default:      burst_open_q <= burst_open_q;
            endcase
        end
    end

    // Purpose: remember that the previous cycle left the device deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)            was_desel_q <= 1'b1;
        else if (sleep_active) was_desel_q <= 1'b1;
        else                   was_desel_q <= (kind == CYC_DESEL);
    end

    // Purpose: one-cycle pipeline stage matching the output register latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= rd_now;
    end

    assign rd_valid   = rd_valid_q;
    assign first_mask = (kind == CYC_RD_START) && was_desel_q;

endmodule

// File: rtl/dcd_oe_hold_chain.sv
// Deselect hold chain: the extra pipelined enable stages that keep the bus
// driven for HOLD cycles after a read when deselects follow. Any cycle that
// is not a deselect, or a flush, empties the chain.
// Assumes HOLD is small (a handful of stages).
module dcd_oe_hold_chain #(
    parameter int HOLD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_valid,
    input  logic is_desel,
    input  logic flush,
    output logic hold_any
);

    generate
        if (HOLD == 0) begin : g_none
            // Single-cycle deselect variant: nothing is held.
            assign hold_any = 1'b0;
        end else begin : g_chain
            logic [HOLD-1:0] stage_q;
            for (genvar i = 0; i < HOLD; i++) begin : g_stage
                logic feed;
                if (i == 0) begin : g_head
                    assign feed = rd_valid;
                end else begin : g_tail
                    assign feed = stage_q[i-1];
                end
                // Purpose: advance one hold stage while deselected.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= feed && is_desel && !flush;
                end
            end
            assign hold_any = |stage_q;
        end
    endgenerate

endmodule

// File: rtl/dcd_oe_pipe.sv
// Top: output enable pipeline for a double-cycle-deselect burst memory.
// Combines the read tracker, the deselect hold chain and the sleep
// synchroniser into the bus drive enable and the output register strobe.
// Assumes cyc_kind is registered upstream; oe_n and sleep_req are
// asynchronous and gate drive_en without clock sampling.
module dcd_oe_pipe
    import dcd_oe_pipe_pkg::*;
#(
    parameter int DESEL_HOLD   = 1,
    parameter int SLEEP_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cyc_kind,
    input  logic       oe_n,
    input  logic       sleep_req,
    output logic       drive_en,
    output logic       oreg_load
);

    cyc_kind_t kind;
    logic      sleep_active;
    logic      rd_now;
    logic      rd_valid;
    logic      first_mask;
    logic      hold_any;
    logic      data_ready;
    logic      blocked;

    assign kind = cyc_kind_t'(cyc_kind);

    dcd_oe_sleep_sync #(.STAGES(SLEEP_STAGES)) u_sleep (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sleep_active (sleep_active)
    );

    dcd_oe_read_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .sleep_active (sleep_active),
        .rd_now       (rd_now),
        .rd_valid     (rd_valid),
        .first_mask   (first_mask)
    );

    dcd_oe_hold_chain #(.HOLD(DESEL_HOLD)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .is_desel (kind == CYC_DESEL),
        .flush    (sleep_active),
        .hold_any (hold_any)
    );

    // Purpose: final gating of the bus drive enable.
    always_comb begin
        data_ready = rd_valid || hold_any;
        blocked    = first_mask || oe_n || (kind == CYC_WRITE)
                     || sleep_req || sleep_active;
        drive_en   = data_ready && !blocked;
    end

    assign oreg_load = rd_now;

endmodule

// File: rtl/dcd_oe_pipe_chk.sv
// Checker: temporal properties of the output enable pipeline, bound to the
// top module. Observes ports only.
module dcd_oe_pipe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cyc_kind,
    input logic       oe_n,
    input logic       sleep_req,
    input logic       drive_en,
    input logic       oreg_load
);

    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'b11) |-> (!drive_en && !oreg_load));

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);

    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !drive_en);

    p_first_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_kind == 2'b01) && ($past(cyc_kind) == 2'b00)) |-> !drive_en);

    p_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc_kind) == 2'b11) |-> !drive_en);

    p_orphan_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cyc_kind) == 2'b11) && (cyc_kind == 2'b10)) |-> !oreg_load);

    p_drive_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($past(oreg_load) || ($past(cyc_kind) == 2'b00)));

endmodule

bind dcd_oe_pipe dcd_oe_pipe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_kind  (cyc_kind),
    .oe_n      (oe_n),
    .sleep_req (sleep_req),
    .drive_en  (drive_en),
    .oreg_load (oreg_load)
);

// File: tb/dcd_oe_pipe_bench.sv
// Bench: two instances (default and longer hold/sleep) against a
// behavioural per-cycle reference model, compared every clock.
module dcd_oe_pipe_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] kind = 2'b00;
    logic       oe_n = 1'b1;
    logic       slp = 1'b0;
    logic       drv0, ld0, drv1, ld1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    dcd_oe_pipe u_dcd_oe_pipe (
        .clk(clk), .rst_n(rst_n), .cyc_kind(kind), .oe_n(oe_n),
        .sleep_req(slp), .drive_en(drv0), .oreg_load(ld0));

    dcd_oe_pipe #(.DESEL_HOLD(2), .SLEEP_STAGES(3)) u_dcd_oe_pipe_h2 (
        .clk(clk), .rst_n(rst_n), .cyc_kind(kind), .oe_n(oe_n),
        .sleep_req(slp), .drive_en(drv1), .oreg_load(ld1));

    // Reference model state, one slot per instance.
    int HOLDV [2] = '{1, 2};
    int SYNCV [2] = '{2, 3};
    int m_rdv [2];
    int m_hold[2];
    int m_open[2];
    int m_dsl [2];
    int m_age [2];

    function automatic bit m_sleep(int i);
        return m_age[i] < SYNCV[i];
    endfunction

    function automatic bit exp_load(int i);
        if (m_sleep(i)) return 1'b0;
        return (kind == 2'd1) || (kind == 2'd2 && m_open[i] != 0);
    endfunction

    function automatic bit exp_drive(int i);
        bit have = (m_rdv[i] != 0) || (m_hold[i] > 0);
        bit mask = (kind == 2'd1) && (m_dsl[i] != 0);
        return have && !mask && !oe_n && kind != 2'd3 && !slp && !m_sleep(i);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_rdv[i] = 0; m_hold[i] = 0; m_open[i] = 0;
            m_dsl[i] = 1; m_age[i] = SYNCV[i];
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            bit act = m_sleep(i);
            int n_rdv  = exp_load(i);
            int n_hold = 0;
            int n_open = m_open[i];
            int n_dsl  = (kind == 2'd0);
            if (kind == 2'd0)
                n_hold = (m_rdv[i] != 0) ? HOLDV[i] : ((m_hold[i] > 0) ? m_hold[i] - 1 : 0);
            if (kind == 2'd1) n_open = 1;
            if (kind == 2'd0 || kind == 2'd3) n_open = 0;
            if (act) begin n_rdv = 0; n_hold = 0; n_open = 0; n_dsl = 1; end
            m_rdv[i] = n_rdv; m_hold[i] = n_hold; m_open[i] = n_open; m_dsl[i] = n_dsl;
            m_age[i] = slp ? 0 : ((m_age[i] < 100) ? m_age[i] + 1 : m_age[i]);
        end
    endtask

    task automatic check1(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check1("drive_en[h1]",  drv0, exp_drive(0));
        check1("oreg_load[h1]", ld0,  exp_load(0));
        check1("drive_en[h2]",  drv1, exp_drive(1));
        check1("oreg_load[h2]", ld1,  exp_load(1));
    endtask

    // One clock cycle: drive inputs away from the edge, compare, advance model.
    task automatic cyc(input logic [1:0] k, input logic o, input logic s);
        @(negedge clk);
        kind = k; oe_n = o; slp = s;
        #2;
        compare_all();
        @(posedge clk);
        model_step();
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        oe_n  = 1'b0;

        cur_req = "R1";                       // reset state, oe low, no read yet
        cyc(2'd0, 0, 0); cyc(2'd0, 0, 0);
        check1("drive_en after reset R1", drv0, 1'b0);

        cur_req = "R2";                       // read starts, back to back
        cyc(2'd0, 0, 0); cyc(2'd1, 0, 0);     // masked first cycle (from deselect)
        cyc(2'd1, 0, 0); cyc(2'd1, 0, 0);
        check1("drive_en during read stream R2", drv0, 1'b1);

        cur_req = "R3";                       // burst continues
        cyc(2'd2, 0, 0); cyc(2'd2, 0, 0); cyc(2'd2, 0, 0);

        cur_req = "R4";                       // deselect hold
        cyc(2'd0, 0, 0); cyc(2'd0, 0, 0); cyc(2'd0, 0, 0); cyc(2'd0, 0, 0);

        cur_req = "R5";                       // read start cuts a running hold
        cyc(2'd1, 0, 0); cyc(2'd2, 0, 0); cyc(2'd0, 0, 0);
        cyc(2'd1, 0, 0); cyc(2'd2, 0, 0); cyc(2'd0, 0, 0);
        cyc(2'd0, 0, 0); cyc(2'd1, 0, 0); cyc(2'd2, 0, 0);

        cur_req = "R6";                       // oe_n gating, incl. mid-cycle toggle
        cyc(2'd2, 1, 0); cyc(2'd2, 0, 0);
        @(negedge clk);
        kind = 2'd2; oe_n = 1'b0; slp = 1'b0;
        #1; compare_all();
        oe_n = 1'b1; #1; compare_all();
        check1("drive_en oe high mid-cycle R6", drv0, 1'b0);
        oe_n = 1'b0; #1; compare_all();
        check1("drive_en oe low mid-cycle R6", drv0, 1'b1);
        @(posedge clk); model_step();

        cur_req = "R7";                       // write forces release
        cyc(2'd3, 0, 0);
        cur_req = "R8";                       // orphaned continues after a write
        cyc(2'd2, 0, 0); cyc(2'd2, 0, 0); cyc(2'd0, 0, 0);
        cyc(2'd1, 0, 0); cyc(2'd2, 0, 0); cyc(2'd3, 0, 0); cyc(2'd1, 0, 0); cyc(2'd2, 0, 0);

        cur_req = "R9";                       // sleep entry and exit
        cyc(2'd2, 0, 1); cyc(2'd0, 0, 1); cyc(2'd0, 0, 1); cyc(2'd0, 0, 1);
        cyc(2'd0, 0, 0); cyc(2'd2, 0, 0); cyc(2'd2, 0, 0); cyc(2'd0, 0, 0);
        cyc(2'd1, 0, 0); cyc(2'd2, 0, 0); cyc(2'd2, 0, 0);
        cyc(2'd1, 0, 0); cyc(2'd2, 0, 1); cyc(2'd2, 0, 0); cyc(2'd2, 0, 0);

        cur_req = "R2";                       // mixed pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[1:0], (lfsr[6:4] == 3'd0), (lfsr[11:8] == 4'd0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule